// File: doc/BRIEF.md
# Wait-State Inserting Bus Subordinate

This block is a memory-style subordinate for a pipelined address/data bus of the AHB kind. It holds a small word-organised register array. It can pace every transfer it answers by holding its ready output low for a chosen number of cycles. One configuration input sets that number, so a single design can stand in for a one-cycle memory or for a slow device that needs several cycles per access. This makes it useful for exercising a manager or an interconnect against mixed response speeds.

The handshake works in two directions. In the address direction, the block consumes an address phase only in a cycle where the bus-wide ready input is high, it is selected, and the transfer type is NONSEQ (2'b10) or SEQ (2'b11). In the data direction, `hreadyout` is the back-pressure signal. While it is low, the manager must keep the data phase and any following address phase unchanged. The data phase ends in the first cycle where the bus-wide ready is high and the wait count has run out. In that cycle, write data is stored and read data is valid. While the bus-wide ready is low for any reason, including a stall from another subordinate, every captured value is held.

Top module: `ahbw_sub`

## Requirements
- R1: After reset, `hreadyout` is 1, `hresp` is 0 (OKAY), no data phase is pending, and every storage word reads as zero.
- R2: When a transfer is captured with wait count W (taken from `wait_cfg` in the capture cycle), `hreadyout` is 0 for exactly the W cycles that follow the capture and is 1 in cycle W+1.
- R3: With W = 0, every transfer completes in the single cycle after its address phase, with `hreadyout` high in that cycle.
- R4: An address phase with `hsel` low, or with `htrans` set to IDLE (2'b00) or BUSY (2'b01), inserts no wait state (`hreadyout` stays 1) and does not change the storage.
- R5: An address phase is ignored when the bus-wide `hready` is low in its cycle. It starts no wait state and no write.
- R6: A write stores `hwdata` in its completing cycle into the word at `haddr[IDX_W+1:2]`. Only the byte lanes set by the captured size and low address bits are written: size 0 writes lane `haddr[1:0]`, size 1 writes lanes 2*`haddr[1]` and 2*`haddr[1]`+1, and size 2 or larger writes all four lanes. Byte lane n is `hwdata[8n+7:8n]`.
- R7: A read presents the whole addressed word on `hrdata` in its completing cycle.
- R8: While `hready` is low, the captured address, direction and size are held. The data phase completes only in a later cycle with `hready` high, using the `hwdata` present in that cycle.
- R9: `hresp` is OKAY (0) in every cycle.
- R10: A change of `wait_cfg` after a transfer has been captured does not alter that transfer's number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Log2 of the transfer size in bytes |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; high means the pipeline advances |
| wait_cfg | input | WAIT_W | Wait cycles to insert for each captured transfer |
| hreadyout | output | 1 | This subordinate's ready; low inserts a wait state |
| hrdata | output | DATA_W | Read data, valid in the completing cycle |
| hresp | output | 1 | Response, always OKAY (0) |

## Verification
An address phase is driven in cycle k and captured at the edge that ends it. `hreadyout` is then due low in cycles k+1 through k+W and high in cycle k+1+W, the same cycle in which `hrdata` is due for a read. A write becomes visible to a read whose data phase starts after that completing edge. The bench drives inputs on the falling edge and samples outputs half a cycle later, before the next rising edge. It counts the W low cycles one by one, so a wait state that arrives early, late or is missing is caught in the exact cycle. Ignored stimulus (deselected, IDLE/BUSY, stalled bus) is checked in the next cycle through `hreadyout`, and afterwards by reading back the word it could have changed.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic RESP_OKAY = 1'b0;

  function automatic logic is_active(input logic [1:0] tr);
    return (tr == TR_NONSEQ) || (tr == TR_SEQ);
  endfunction
endpackage

// File: rtl/ahbw_addr_stage.sv
module ahbw_addr_stage
  import ahbw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hready,
  output logic              accept,
  output logic              dp_valid,
  output logic              cap_write,
  output logic [2:0]        cap_size,
  output logic [ADDR_W-1:0] cap_addr
);
  assign accept = hsel && hready && is_active(htrans);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid  <= 1'b0;
      cap_write <= 1'b0;
      cap_size  <= '0;
      cap_addr  <= '0;
    end else if (hready) begin
      dp_valid <= accept;
      if (accept) begin
        cap_write <= hwrite;
        cap_size  <= hsize;
        cap_addr  <= haddr;
      end
    end
  end

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(cap_addr) && $stable(cap_write) && $stable(cap_size))) else $error("hold"); // R8

  AST_NO_CAPTURE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && !dp_valid) |=> !dp_valid) else $error("stall capture"); // R5
endmodule

// File: rtl/ahbw_wait_ctr.sv
module ahbw_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] cfg,
  input  logic              dp_valid,
  output logic              ready_out
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= cfg;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ready_out = (cnt == '0);

  AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_valid |-> ready_out) else $error("wait without transfer"); // R4

  AST_WAIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg != '0) |=> (!ready_out && dp_valid)) else $error("wait start"); // R2

  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg == '0) |=> ready_out) else $error("zero wait"); // R3
endmodule

// File: rtl/ahbw_store.sv
module ahbw_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [LANES-1:0] lane_en;

  always_comb begin
    int nbytes;
    int base;
    nbytes = (int'(size) >= OFF_W) ? LANES : (1 << size);
    base   = int'(off) & ~(nbytes - 1);
    for (int l = 0; l < LANES; l++) begin
      lane_en[l] = (l >= base) && (l < base + nbytes);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bank [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int d = 0; d < DEPTH; d++) bank[d] <= '0;
      end else if (we && lane_en[g]) begin
        bank[idx] <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = bank[idx];
  end
endmodule

// File: rtl/ahbw_sub.sv
module ahbw_sub
  import ahbw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              hreadyout,
  output logic [DATA_W-1:0] hrdata,
  output logic              hresp
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = $clog2(DEPTH);

  logic              accept;
  logic              dp_valid;
  logic              cap_write;
  logic [2:0]        cap_size;
  logic [ADDR_W-1:0] cap_addr;
  logic              ctr_ready;
  logic              finish_w;

  ahbw_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk(hclk), .rst_n(hresetn), .hsel(hsel), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .haddr(haddr), .hready(hready),
    .accept(accept), .dp_valid(dp_valid), .cap_write(cap_write),
    .cap_size(cap_size), .cap_addr(cap_addr)
  );

  ahbw_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk(hclk), .rst_n(hresetn), .load(accept), .cfg(wait_cfg),
    .dp_valid(dp_valid), .ready_out(ctr_ready)
  );

  assign finish_w = dp_valid && ctr_ready && hready && cap_write;

  ahbw_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(hclk), .rst_n(hresetn), .we(finish_w),
    .idx(cap_addr[OFF_W +: IDX_W]), .off(cap_addr[OFF_W-1:0]),
    .size(cap_size), .wdata(hwdata), .rdata(hrdata)
  );

  assign hreadyout = ctr_ready;
  assign hresp     = RESP_OKAY;

  AST_STALL_KEEPS_PENDING: assert property (@(posedge hclk) disable iff (!hresetn)
    (dp_valid && !hready) |=> dp_valid) else $error("pending lost"); // R8

  AST_RESET_READY: assert property (@(posedge hclk)
    !hresetn |=> hreadyout) else $error("reset ready"); // R1
endmodule

// File: tb/tb_ahbw_sub.sv
module tb_ahbw_sub;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int WAIT_W = 4;

  logic              hclk = 1'b0;
  logic              hresetn = 1'b0;
  logic              hsel = 1'b0;
  logic [ADDR_W-1:0] haddr = '0;
  logic [1:0]        htrans = 2'b00;
  logic              hwrite = 1'b0;
  logic [2:0]        hsize = 3'd2;
  logic [DATA_W-1:0] hwdata = '0;
  logic              ext_stall = 1'b0;
  logic [WAIT_W-1:0] wait_cfg = '0;
  logic              hready;
  logic              hreadyout;
  logic [DATA_W-1:0] hrdata;
  logic              hresp;

  logic [DATA_W-1:0] model [DEPTH];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  assign hready = hreadyout && !ext_stall;

  always #10 hclk = ~hclk;

  ahbw_sub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WAIT_W(WAIT_W)) dut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .wait_cfg(wait_cfg), .hreadyout(hreadyout), .hrdata(hrdata), .hresp(hresp)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] wd,
                                              input int sz, input int off);
    logic [DATA_W-1:0] r;
    int nb;
    int base;
    r = old;
    nb = (sz >= 2) ? 4 : (1 << sz);
    base = (off / nb) * nb;
    for (int l = base; l < base + nb; l++) r[8*l +: 8] = wd[8*l +: 8];
    return r;
  endfunction

  // One transfer, followed by IDLE; returns after the completing edge.
  task automatic xfer(input bit wr, input int addr, input int sz, input logic [DATA_W-1:0] wd,
                      input int waits, input bit cfg_change);
    int idx;
    idx = (addr >> 2) % DEPTH;
    hsel = 1'b1; htrans = 2'b10; hwrite = wr; haddr = ADDR_W'(addr); hsize = 3'(sz);
    wait_cfg = WAIT_W'(waits);
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    if (cfg_change) wait_cfg = '0; // R10: must not shorten the current transfer
    for (int i = 0; i < waits; i++) begin
      check(cfg_change ? "R10 wait kept" : "R2 wait low", DATA_W'(hreadyout), '0);
      check("R9 okay", DATA_W'(hresp), '0);
      @(negedge hclk);
    end
    check(waits == 0 ? "R3 zero wait" : "R2 ready after W", DATA_W'(hreadyout), 1);
    if (!wr) check("R7 read data", hrdata, model[idx]);
    else model[idx] = merge(model[idx], wd, sz, addr & 3);
    @(negedge hclk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < DEPTH; d++) model[d] = '0;
    repeat (3) @(negedge hclk);
    check("R1 ready at reset", DATA_W'(hreadyout), 1);
    check("R1 okay at reset", DATA_W'(hresp), '0);
    hresetn = 1'b1;
    @(negedge hclk);
    check("R1 ready after reset", DATA_W'(hreadyout), 1);
    xfer(0, 20, 2, '0, 0, 0); // R1 storage zero

    // R6 R7 R2 R3: sweep waits, sizes and offsets
    for (int w = 0; w < 4; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off += (1 << sz)) begin
          int a;
          a = ((w * 3 + sz) % DEPTH) * 4 + off;
          xfer(1, a, sz, 32'hA1B2C3D4 ^ (w * 32'h01010101) ^ (off << 8), w, 0);
          xfer(0, a & ~3, 2, '0, w, 0);
        end

    // R4: deselected and IDLE/BUSY writes do nothing
    for (int k = 0; k < 3; k++) begin
      hsel = (k != 0); htrans = (k == 2) ? 2'b01 : (k == 1 ? 2'b00 : 2'b10);
      hwrite = 1'b1; haddr = 8'd4; hsize = 3'd2; wait_cfg = 4'd3;
      @(negedge hclk);
      hsel = 1'b0; htrans = 2'b00; hwdata = 32'hDEADBEEF;
      check("R4 no wait", DATA_W'(hreadyout), 1);
      @(negedge hclk);
    end
    xfer(0, 4, 2, '0, 0, 0); // R4 storage unchanged

    // R5: address phase while bus stalled elsewhere is ignored
    ext_stall = 1'b1;
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 8'd8; hsize = 3'd2; wait_cfg = 4'd2;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; ext_stall = 1'b0; hwdata = 32'h55555555;
    check("R5 no wait", DATA_W'(hreadyout), 1);
    @(negedge hclk);
    xfer(0, 8, 2, '0, 0, 0); // R5 storage unchanged

    // R8: completion held by bus stall; new address offered during stall ignored
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 8'd12; hsize = 3'd2; wait_cfg = 4'd1;
    @(negedge hclk);
    htrans = 2'b10; haddr = 8'd16; hwdata = 32'h11111111; // next phase, not accepted while low
    check("R8 wait low", DATA_W'(hreadyout), '0);
    @(negedge hclk);
    ext_stall = 1'b1;
    check("R8 own ready", DATA_W'(hreadyout), 1);
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; hwdata = 32'hCAFEF00D;
    check("R8 held", DATA_W'(hreadyout), 1);
    @(negedge hclk);
    ext_stall = 1'b0;
    @(negedge hclk);
    model[3] = 32'hCAFEF00D;
    check("R8 no extra wait", DATA_W'(hreadyout), 1);
    xfer(0, 12, 2, '0, 0, 0); // R8 final hwdata stored
    xfer(0, 16, 2, '0, 0, 0); // R8 stalled phase not captured

    // R10: config change mid-transfer
    xfer(0, 12, 2, '0, 3, 1);
    xfer(1, 40, 2, 32'h0BADF00D, 5, 1);
    xfer(0, 40, 2, '0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule